// File: doc/BRIEF.md
# Transmit Packet Staging Buffer

This block sits between user logic and a downstream link layer on the transmit side. User logic hands over command packets and any data payload as 64-bit beats. Each beat carries two 32-bit doublewords: the even doubleword in bits 31:0 and the odd doubleword in bits 63:32. Beats are qualified by `dat_en`, and `sop`/`eop` mark the first and last beat of a packet. The block frames each packet and decides whether it is a read response or a write from its header. It counts the payload doublewords and keeps whole packets in a small slot FIFO. The link layer drains that FIFO one beat at a time through a valid/take port.

Admission is judged per whole command. `space_avail` high means one more complete packet fits. A packet that has been admitted is always taken in full, even if `space_avail` falls while it is in progress. A start that cannot be stored, or a beat sequence that breaks framing, raises `wr_reject` and the offending packet is discarded as a whole.

The framing engine has three states. IDLE means no packet is open. OPEN means an admitted packet is collecting beats. DROP means the beats of a refused or broken packet are being discarded. The transitions are:
- IDLE to OPEN: admitted start.
- IDLE to IDLE: admitted single-beat packet, which is committed at once, or a stray end, which is rejected.
- IDLE to DROP: refused start without end.
- OPEN to IDLE: end beat commits the packet, or a nested start or overflow occurs on an end beat.
- OPEN to DROP: nested start or overflow without end.
- DROP to IDLE: end beat.

Top module: `tx_pkt_buffer`

## Requirements
- R1: Reset empties the FIFO and closes any open packet. On the first cycle after reset is released, `space_avail` is 1, `out_valid` is 0 and `wr_reject` is 0.
- R2: `space_avail` is registered. After each clock edge it is 1 exactly when stored packets plus the open packet (0 or 1) is below SLOTS (default 4).
- R3: On a cycle with `dat_en` low, `dat`, `sop`, `eop` and `empty` have no effect on packets, framing or `wr_reject`, so wait states may be inserted anywhere.
- R4: Once a start beat is admitted, every following beat of that packet is stored even after `space_avail` has dropped to 0.
- R5: A start beat that arrives while `space_avail` is 0 is refused. `wr_reject` is 1 for one cycle after that edge, and no beat of that packet is stored.
- R6: The header is the low doubleword of the start beat. If its bits 5:0 equal RESP_CODE (default 6'h30), the packet is a read response: `out_write` is 0 and bits 63:32 of the start beat are stored as zero. Any other code marks a write: `out_write` is 1 and the upper doubleword (address bits 39:8) is kept.
- R7: `out_dwords` counts the payload doublewords. The start beat contributes none. Every non-final payload beat contributes 2. The end beat contributes ceil((8 - empty) / 4), so `empty` 0..3 gives 2 and 4..7 gives 1.
- R8: A start beat while a packet is open discards the open packet, drops the new packet up to its end, and raises `wr_reject`. An end beat with no packet open and no start also raises `wr_reject`.
- R9: A packet longer than MAX_BEATS beats (default 8) is discarded and `wr_reject` is raised on the first excess beat. A packet of exactly MAX_BEATS beats is stored.
- R10: While any packet is stored, `out_valid` is 1. The head beat appears on `out_data`, with `out_first` on beat 0 and `out_last` on the final beat. Each cycle with `out_take` high advances one beat, and packets leave in arrival order. The head stays unchanged while `out_take` is low.
- R11: `out_take` while `out_valid` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| space_avail | output | 1 | One more complete packet can be accepted |
| dat_en | input | 1 | Qualifies the beat on the inputs below |
| dat | input | 64 | Beat data, even doubleword low, odd doubleword high |
| sop | input | 1 | First beat of a packet |
| eop | input | 1 | Last beat of a packet |
| empty | input | 3 | Unused bytes on the end beat |
| wr_reject | output | 1 | Packet refused or framing broken |
| out_valid | output | 1 | A stored packet beat is at the head |
| out_data | output | 64 | Head beat |
| out_first | output | 1 | Head beat is the packet's first |
| out_last | output | 1 | Head beat is the packet's last |
| out_write | output | 1 | Head packet is a write (0: read response) |
| out_dwords | output | 5 | Payload doubleword count of the head packet |
| out_take | input | 1 | Consume the head beat |

## Verification
The properties assume that `dat_en` is never X after reset and that the drain side only raises `out_take` as a plain request. They assume nothing about framing: nested starts, stray ends and overlong packets are all legal stimulus with defined outcomes. The stimulus always drives inputs on the falling edge. During every user wait state it deliberately presents junk with `sop` and `eop` high, so the property that state holds while `dat_en` is low is exercised against hostile values rather than idle ones.

// File: rtl/tx_pkt_pkg.sv
package tx_pkt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPEN = 2'd1,
        ST_DROP = 2'd2
    } frm_state_e;

    // Doublewords carried by the final beat: ceil((8 - empty) / 4)
    function automatic logic [1:0] tail_dwords(input logic [2:0] empty_bytes);
        logic [3:0] t;
        t = 4'd11 - {1'b0, empty_bytes};
        return t[3:2];
    endfunction

endpackage

// File: rtl/tx_pkt_framer.sv
module tx_pkt_framer
    import tx_pkt_pkg::*;
#(
    parameter int MAX_BEATS = 8,
    parameter logic [5:0] RESP_CODE = 6'h30,
    localparam int BW  = $clog2(MAX_BEATS + 1),
    localparam int DWW = $clog2(2 * MAX_BEATS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           space_ok,
    input  logic           dat_en,
    input  logic [63:0]    dat,
    input  logic           sop,
    input  logic           eop,
    input  logic [2:0]     empty,
    output logic           wr_reject,
    output logic           open_next,
    output logic           beat_we,
    output logic [BW-1:0]  wr_idx,
    output logic [63:0]    beat_data,
    output logic           commit,
    output logic           commit_write,
    output logic [DWW-1:0] commit_dwords,
    output logic [BW-1:0]  commit_beats
);

    frm_state_e     state_q, state_d;
    logic [BW-1:0]  idx_q, idx_d;
    logic           write_q, write_d;
    logic [DWW-1:0] dw_q, dw_d;
    logic           rej_q, rej_d;
    logic           hdr_write;

    assign hdr_write = (dat[5:0] != RESP_CODE);
    assign open_next = (state_d == ST_OPEN);
    assign wr_reject = rej_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            write_q <= 1'b0;
            dw_q    <= '0;
            rej_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            write_q <= write_d;
            dw_q    <= dw_d;
            rej_q   <= rej_d;
        end
    end

    // Transitions and beat outputs
    always_comb begin
        state_d       = state_q;
        idx_d         = idx_q;
        write_d       = write_q;
        dw_d          = dw_q;
        rej_d         = 1'b0;
        beat_we       = 1'b0;
        wr_idx        = idx_q;
        beat_data     = dat;
        commit        = 1'b0;
        commit_write  = write_q;
        commit_dwords = dw_q;
        commit_beats  = idx_q + BW'(1);
        unique case (state_q)
            ST_IDLE: begin
                wr_idx = '0;
                if (dat_en && sop) begin
                    if (!space_ok) begin
                        rej_d   = 1'b1;
                        state_d = eop ? ST_IDLE : ST_DROP;
                    end else begin
                        beat_we   = 1'b1;
                        beat_data = hdr_write ? dat : {32'h0, dat[31:0]};
                        write_d   = hdr_write;
                        dw_d      = '0;
                        if (eop) begin
                            commit        = 1'b1;
                            commit_write  = hdr_write;
                            commit_dwords = '0;
                            commit_beats  = BW'(1);
                        end else begin
                            state_d = ST_OPEN;
                            idx_d   = BW'(1);
                        end
                    end
                end else if (dat_en && eop) begin
                    rej_d = 1'b1;
                end
            end
            ST_OPEN: begin
                if (dat_en) begin
                    if (sop || (idx_q == BW'(MAX_BEATS))) begin
                        rej_d   = 1'b1;
                        state_d = eop ? ST_IDLE : ST_DROP;
                    end else begin
                        beat_we = 1'b1;
                        if (eop) begin
                            commit        = 1'b1;
                            commit_dwords = dw_q + DWW'(tail_dwords(empty));
                            state_d       = ST_IDLE;
                        end else begin
                            dw_d  = dw_q + DWW'(2);
                            idx_d = idx_q + BW'(1);
                        end
                    end
                end
            end
            ST_DROP: begin
                if (dat_en && eop) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R3
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_en |=> ($stable(state_q) && !wr_reject));

    // R4
    keep_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && dat_en && !sop && !eop && idx_q < BW'(MAX_BEATS))
        |=> (state_q == ST_OPEN && !wr_reject));

    // R5
    late_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && dat_en && sop && !space_ok) |=> wr_reject);

    // R8
    nested_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && dat_en && sop) |=> (wr_reject && state_q != ST_OPEN));

    // R7
    dword_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (int'(commit_dwords) <= 2 * (int'(commit_beats) - 1)));

endmodule

// File: rtl/tx_pkt_store.sv
module tx_pkt_store #(
    parameter int SLOTS = 4,
    parameter int MAX_BEATS = 8,
    localparam int BW  = $clog2(MAX_BEATS + 1),
    localparam int DWW = $clog2(2 * MAX_BEATS + 1),
    localparam int CW  = $clog2(SLOTS + 1),
    localparam int PW  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int AW  = $clog2(SLOTS * MAX_BEATS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           beat_we,
    input  logic [BW-1:0]  wr_idx,
    input  logic [63:0]    beat_data,
    input  logic           commit,
    input  logic           commit_write,
    input  logic [DWW-1:0] commit_dwords,
    input  logic [BW-1:0]  commit_beats,
    output logic [CW-1:0]  count_next,
    output logic           out_valid,
    output logic [63:0]    out_data,
    output logic           out_first,
    output logic           out_last,
    output logic           out_write,
    output logic [DWW-1:0] out_dwords,
    input  logic           out_take
);

    logic [63:0]    mem [SLOTS * MAX_BEATS];
    logic           desc_write [SLOTS];
    logic [DWW-1:0] desc_dw    [SLOTS];
    logic [BW-1:0]  desc_beats [SLOTS];

    logic [PW-1:0]  wr_ptr, rd_ptr;
    logic [BW-1:0]  rd_beat;
    logic [CW-1:0]  count_q;
    logic [AW-1:0]  wa, ra;
    logic           pop_last;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(SLOTS - 1)) ? '0 : p + PW'(1);
    endfunction

    assign wa = AW'(wr_ptr) * AW'(MAX_BEATS) + AW'(wr_idx);
    assign ra = AW'(rd_ptr) * AW'(MAX_BEATS) + AW'(rd_beat);

    assign out_valid  = (count_q != '0);
    assign out_data   = mem[ra];
    assign out_first  = (rd_beat == '0);
    assign out_last   = (rd_beat == desc_beats[rd_ptr] - BW'(1));
    assign out_write  = desc_write[rd_ptr];
    assign out_dwords = desc_dw[rd_ptr];
    assign pop_last   = out_valid && out_take && out_last;
    assign count_next = count_q + CW'(commit) - CW'(pop_last);

    always_ff @(posedge clk) begin
        if (beat_we) mem[wa] <= beat_data;
        if (commit) begin
            desc_write[wr_ptr] <= commit_write;
            desc_dw[wr_ptr]    <= commit_dwords;
            desc_beats[wr_ptr] <= commit_beats;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            rd_beat <= '0;
            count_q <= '0;
        end else begin
            count_q <= count_next;
            if (commit) wr_ptr <= ptr_inc(wr_ptr);
            if (out_valid && out_take) begin
                if (out_last) begin
                    rd_beat <= '0;
                    rd_ptr  <= ptr_inc(rd_ptr);
                end else begin
                    rd_beat <= rd_beat + BW'(1);
                end
            end
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (count_q < CW'(SLOTS)));

    // R10
    hold_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_take) |=> (out_valid && $stable(out_data)));

    // R11
    idle_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !commit) |=> !out_valid);

endmodule

// File: rtl/tx_pkt_space.sv
module tx_pkt_space #(
    parameter int SLOTS = 4,
    localparam int CW = $clog2(SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count_next,
    input  logic          open_next,
    output logic          space_avail
);

    logic [CW:0] used;

    assign used = {1'b0, count_next} + (CW + 1)'(open_next);

    always_ff @(posedge clk) begin
        if (!rst_n) space_avail <= 1'b1;
        else        space_avail <= (used < (CW + 1)'(SLOTS));
    end

endmodule

// File: rtl/tx_pkt_buffer.sv
module tx_pkt_buffer #(
    parameter int SLOTS = 4,
    parameter int MAX_BEATS = 8,
    parameter logic [5:0] RESP_CODE = 6'h30,
    localparam int BW  = $clog2(MAX_BEATS + 1),
    localparam int DWW = $clog2(2 * MAX_BEATS + 1),
    localparam int CW  = $clog2(SLOTS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic           space_avail,
    input  logic           dat_en,
    input  logic [63:0]    dat,
    input  logic           sop,
    input  logic           eop,
    input  logic [2:0]     empty,
    output logic           wr_reject,
    output logic           out_valid,
    output logic [63:0]    out_data,
    output logic           out_first,
    output logic           out_last,
    output logic           out_write,
    output logic [DWW-1:0] out_dwords,
    input  logic           out_take
);

    logic           open_next;
    logic           beat_we;
    logic [BW-1:0]  wr_idx;
    logic [63:0]    beat_data;
    logic           commit;
    logic           commit_write;
    logic [DWW-1:0] commit_dwords;
    logic [BW-1:0]  commit_beats;
    logic [CW-1:0]  count_next;

    tx_pkt_framer #(
        .MAX_BEATS (MAX_BEATS),
        .RESP_CODE (RESP_CODE)
    ) u_framer (
        .clk           (clk),
        .rst_n         (rst_n),
        .space_ok      (space_avail),
        .dat_en        (dat_en),
        .dat           (dat),
        .sop           (sop),
        .eop           (eop),
        .empty         (empty),
        .wr_reject     (wr_reject),
        .open_next     (open_next),
        .beat_we       (beat_we),
        .wr_idx        (wr_idx),
        .beat_data     (beat_data),
        .commit        (commit),
        .commit_write  (commit_write),
        .commit_dwords (commit_dwords),
        .commit_beats  (commit_beats)
    );

    tx_pkt_store #(
        .SLOTS     (SLOTS),
        .MAX_BEATS (MAX_BEATS)
    ) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .beat_we       (beat_we),
        .wr_idx        (wr_idx),
        .beat_data     (beat_data),
        .commit        (commit),
        .commit_write  (commit_write),
        .commit_dwords (commit_dwords),
        .commit_beats  (commit_beats),
        .count_next    (count_next),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .out_first     (out_first),
        .out_last      (out_last),
        .out_write     (out_write),
        .out_dwords    (out_dwords),
        .out_take      (out_take)
    );

    tx_pkt_space #(
        .SLOTS (SLOTS)
    ) u_space (
        .clk         (clk),
        .rst_n       (rst_n),
        .count_next  (count_next),
        .open_next   (open_next),
        .space_avail (space_avail)
    );

    // R1
    reset_space_chk: assert property (@(posedge clk)
        !rst_n |=> (space_avail && !out_valid && !wr_reject));

endmodule

// File: tb/tx_pkt_buffer_bench.sv
`timescale 1ns/1ps
module tx_pkt_buffer_bench;

    localparam int SLOTS = 4;
    localparam int MAX_BEATS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        space_avail, wr_reject;
    logic        dat_en = 1'b0, sop = 1'b0, eop = 1'b0;
    logic [63:0] dat = '0;
    logic [2:0]  empty = '0;
    logic        out_valid, out_first, out_last, out_write;
    logic [63:0] out_data;
    logic [4:0]  out_dwords;
    logic        out_take = 1'b0;

    int checks = 0;
    int failures = 0;
    int rej_cnt = 0;

    always #2 clk = ~clk;

    tx_pkt_buffer #(.SLOTS(SLOTS), .MAX_BEATS(MAX_BEATS)) u_tx_pkt_buffer (
        .clk(clk), .rst_n(rst_n), .space_avail(space_avail), .dat_en(dat_en),
        .dat(dat), .sop(sop), .eop(eop), .empty(empty), .wr_reject(wr_reject),
        .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
        .out_last(out_last), .out_write(out_write), .out_dwords(out_dwords),
        .out_take(out_take)
    );

    always @(negedge clk) if (rst_n && wr_reject) rej_cnt++;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] dv(input int id, input int k);
        return 32'hD000_0000 | (32'(id) << 12) | 32'(k);
    endfunction

    function automatic logic [63:0] drive_beat(input int id, input bit w, input int n, input int j);
        logic [31:0] lo, hi;
        int k;
        if (j == 0) begin
            lo = {16'h0, 8'(id), 2'b00, (w ? 6'h2C : 6'h30)};
            hi = w ? (32'hA000_0000 | 32'(id)) : (32'hBAD0_0000 | 32'(id));
        end else begin
            k  = 2 * (j - 1);
            lo = dv(id, k);
            hi = (k + 1 < n) ? dv(id, k + 1) : (32'hEEEE_0000 | 32'(id));
        end
        return {hi, lo};
    endfunction

    function automatic logic [63:0] exp_beat(input int id, input bit w, input int n, input int j);
        logic [63:0] b;
        b = drive_beat(id, w, n, j);
        if (j == 0 && !w) b[63:32] = 32'h0;
        return b;
    endfunction

    function automatic logic [2:0] last_empty(input int id, input int n);
        if (n == 0) return 3'd0;
        return (n % 2 == 1) ? 3'(4 + id % 4) : 3'(id % 4);
    endfunction

    task automatic drive_raw(input bit en, input bit s, input bit e, input logic [63:0] d);
        dat_en = en; sop = s; eop = e; dat = d; empty = 3'd0;
        @(negedge clk);
        dat_en = 1'b0; sop = 1'b0; eop = 1'b0;
    endtask

    task automatic send_pkt(input int id, input bit w, input int n, input int gap,
                            input int exp_sp, input int exp_rj);
        int nb;
        nb = 1 + (n + 1) / 2;
        for (int j = 0; j < nb; j++) begin
            if (gap > 0 && (j % gap) == gap - 1) begin
                // R3 wait state with hostile junk
                dat_en = 1'b0; sop = 1'b1; eop = 1'b1; empty = 3'd5;
                dat = 64'hDEAD_BEEF_0BAD_F00D ^ 64'(j);
                @(negedge clk);
            end
            dat_en = 1'b1; sop = (j == 0); eop = (j == nb - 1);
            empty = (j == nb - 1) ? last_empty(id, n) : 3'd6;
            dat = drive_beat(id, w, n, j);
            @(negedge clk);
            if (j == 0) begin
                if (exp_sp >= 0) chk(space_avail == exp_sp[0], "R2 space after start", 64'(space_avail), 64'(exp_sp));
                if (exp_rj >= 0) chk(wr_reject == exp_rj[0], "R5 reject after start", 64'(wr_reject), 64'(exp_rj));
            end
        end
        dat_en = 1'b0; sop = 1'b0; eop = 1'b0;
    endtask

    task automatic drain_check(input int id, input bit w, input int n);
        int nb;
        nb = 1 + (n + 1) / 2;
        for (int j = 0; j < nb; j++) begin
            chk(out_valid == 1'b1, "R10 valid", 64'(out_valid), 64'd1);
            chk(out_data == exp_beat(id, w, n, j), (j == 0) ? "R6 header beat" : "R10 data beat",
                out_data, exp_beat(id, w, n, j));
            chk({out_first, out_last} == {j == 0, j == nb - 1}, "R10 first/last",
                64'({out_first, out_last}), 64'({j == 0, j == nb - 1}));
            if (j == 0) begin
                chk(out_write == w, "R6 class", 64'(out_write), 64'(w));
                chk(out_dwords == 5'(n), "R7 dword count", 64'(out_dwords), 64'(n));
            end
            out_take = 1'b1;
            @(negedge clk);
        end
        out_take = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int id;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        chk(space_avail == 1'b1, "R1 space", 64'(space_avail), 64'd1);
        chk(out_valid == 1'b0, "R1 valid", 64'(out_valid), 64'd0);
        chk(wr_reject == 1'b0, "R1 reject", 64'(wr_reject), 64'd0);
        @(negedge clk);

        // Sweep: both classes, every payload length up to the beat limit
        id = 1;
        for (int w = 0; w < 2; w++) begin
            for (int n = 0; n <= 2 * (MAX_BEATS - 1); n++) begin
                send_pkt(id, w[0], n, n % 4, -1, -1);
                drain_check(id, w[0], n);
                id++;
            end
        end
        // R3
        chk(rej_cnt == 0, "R3 no reject from wait-state junk", 64'(rej_cnt), 64'd0);

        // R2 / R4: fill every slot; last packet continues after space drops
        for (int k = 0; k < SLOTS; k++) begin
            send_pkt(id + k, 1'b1, 3, (k == SLOTS - 1) ? 2 : 0, (k < SLOTS - 1) ? 1 : 0, 0);
            chk(space_avail == (k < SLOTS - 1), "R2 space after commit",
                64'(space_avail), 64'(k < SLOTS - 1));
        end
        // R5: start while full is refused
        send_pkt(id + SLOTS, 1'b0, 2, 0, 0, 1);
        chk(wr_reject == 1'b0, "R5 one-cycle pulse", 64'(wr_reject), 64'd0);
        for (int k = 0; k < SLOTS; k++) drain_check(id + k, 1'b1, 3);
        chk(out_valid == 1'b0, "R5 refused packet not stored", 64'(out_valid), 64'd0);
        chk(space_avail == 1'b1, "R2 space after drain", 64'(space_avail), 64'd1);
        id = id + SLOTS + 1;

        // R11
        out_take = 1'b1;
        repeat (3) @(negedge clk);
        out_take = 1'b0;
        chk(out_valid == 1'b0, "R11 take while empty", 64'(out_valid), 64'd0);
        chk(space_avail == 1'b1, "R11 space unchanged", 64'(space_avail), 64'd1);
        send_pkt(id, 1'b0, 5, 0, -1, -1);
        drain_check(id, 1'b0, 5);
        id++;

        // R8: nested start, then stray end
        drive_raw(1'b1, 1'b1, 1'b0, drive_beat(id, 1'b1, 4, 0));
        chk(wr_reject == 1'b0, "R8 first start accepted", 64'(wr_reject), 64'd0);
        drive_raw(1'b1, 1'b0, 1'b0, drive_beat(id, 1'b1, 4, 1));
        drive_raw(1'b1, 1'b1, 1'b0, drive_beat(id, 1'b1, 4, 0));
        chk(wr_reject == 1'b1, "R8 nested start reject", 64'(wr_reject), 64'd1);
        drive_raw(1'b1, 1'b0, 1'b1, drive_beat(id, 1'b1, 4, 2));
        chk(out_valid == 1'b0, "R8 broken packets discarded", 64'(out_valid), 64'd0);
        drive_raw(1'b1, 1'b0, 1'b1, 64'h1234);
        chk(wr_reject == 1'b1, "R8 stray end reject", 64'(wr_reject), 64'd1);
        chk(out_valid == 1'b0, "R8 stray end not stored", 64'(out_valid), 64'd0);
        send_pkt(id, 1'b1, 4, 0, -1, -1);
        drain_check(id, 1'b1, 4);
        id++;

        // R9: one beat over the limit
        send_pkt(id, 1'b1, 2 * MAX_BEATS, 0, -1, -1);
        chk(wr_reject == 1'b1, "R9 overlong reject", 64'(wr_reject), 64'd1);
        chk(out_valid == 1'b0, "R9 overlong not stored", 64'(out_valid), 64'd0);
        send_pkt(id + 1, 1'b0, 7, 0, -1, -1);
        drain_check(id + 1, 1'b0, 7);
        id = id + 2;

        // R1: reset mid-stream with stored packets and an open one
        send_pkt(id, 1'b1, 1, 0, -1, -1);
        send_pkt(id + 1, 1'b0, 2, 0, -1, -1);
        drive_raw(1'b1, 1'b1, 1'b0, drive_beat(id + 2, 1'b1, 2, 0));
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk(out_valid == 1'b0, "R1 reset empties", 64'(out_valid), 64'd0);
        chk(space_avail == 1'b1, "R1 space after reset", 64'(space_avail), 64'd1);
        send_pkt(id + 3, 1'b1, 6, 0, -1, -1);
        drain_check(id + 3, 1'b1, 6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule